// File: doc/BRIEF.md
# DMA Buffer Descriptor Sequencer

This block is a single DMA channel that works through a table of buffer descriptors held in ordinary memory. Every descriptor is 16 bytes long. It holds a control word with flags, a byte count, a source pointer and a destination pointer. For each descriptor the channel fetches those four words, copies the requested bytes one word at a time from source to destination, and writes the control word back with its valid flag cleared. It then raises an event if the descriptor asked for one and moves on to the next descriptor. All descriptor and data traffic uses one word-wide memory master port. That port has a valid/ready handshake and allows one access in flight.

The control flags decide how the channel proceeds:
- A descriptor that is not valid stops the channel and raises a not-ready event.
- A wrap flag sends the next fetch back to the table base.
- A last flag ends a chain.
- A continuous flag keeps the descriptor valid, so the table can be reused without software refilling it.

Software starts the channel with a one-cycle start pulse. The first start after reset begins at the table base. A later start resumes at the descriptor where the channel stopped. Two sticky events, each with a mask bit, are combined into one interrupt line.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, `busy`, `evt_bc`, `evt_nr`, `irq` and `mem_req` are all low.
- R2: The first `start` after reset sets the descriptor pointer to `tbl_base`. Any later `start` resumes at the descriptor address where the channel halted.
- R3: A descriptor is laid out as follows: the control word at offset 0, the byte count in the low 16 bits of the word at offset 4, the source pointer at offset 8 and the destination pointer at offset 12. In the control word, bit 31 is valid, bit 29 is wrap, bit 28 is interrupt, bit 27 is last and bit 25 is continuous. Without wrap, the next descriptor is at the current address plus 16.
- R4: If the control word read has its valid bit clear, `evt_nr` is set, `busy` falls, and no further memory access is made until the next `start`.
- R5: The copy reads one source word and then writes one destination word, with both pointers advancing by 4. The final write of a count that is not a multiple of 4 enables only the low n byte lanes, where lane i is `mem_be[i]` and covers data bits 8i+7 to 8i. A count of zero makes no data accesses.
- R6: After the data is moved, the control word is written back with bit 31 cleared and every other bit unchanged. When the continuous bit is set, no write-back is made.
- R7: After a descriptor with wrap set, the next control-word fetch is at `tbl_base`.
- R8: `evt_bc` is set when a descriptor with the interrupt bit finishes. It is not set by a descriptor without that bit.
- R9: With continuous clear, a descriptor with last set halts the channel (`busy` low) after it is serviced. With continuous set, the last bit is ignored.
- R10: Events stay set until a one on the matching `evt_clr` bit clears them (bit 0 for `evt_bc`, bit 1 for `evt_nr`). A set and a clear in the same cycle leave the event set.
- R11: `irq` is high exactly when some event bit is high and its `evt_mask` bit is high.
- R12: While `mem_req` is high and `mem_ready` is low, address, write enable, write data and byte enables hold their values into the next cycle.
- R13: `busy` is high from a start until the channel halts. A `start` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle start command |
| tbl_base | input | 32 | Descriptor table base address |
| evt_clr | input | 2 | Write-one-to-clear strobes for the events |
| evt_mask | input | 2 | Interrupt enable for each event |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, valid with ready |
| mem_ready | input | 1 | Access completes in this cycle |
| busy | output | 1 | Channel is running |
| evt_bc | output | 1 | Buffer-complete event |
| evt_nr | output | 1 | Descriptor-not-ready event |
| irq | output | 1 | Masked OR of the events |

## Verification
The buffer-complete event can be set in the same cycle that software clears it. The bench provokes this by holding the clear strobe for that event high for a whole run of a descriptor that requests an interrupt. The rule is judged by whether the event is seen high for at least one cycle and then found low once the run is over. A second start pulse given during that same run must leave the access counts at the values of a single pass.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    // control word flag positions
    localparam int FLG_VALID = 31;
    localparam int FLG_WRAP  = 29;
    localparam int FLG_INTR  = 28;
    localparam int FLG_LAST  = 27;
    localparam int FLG_CONT  = 25;

    // descriptor word offsets
    localparam int OFF_LEN    = 4;
    localparam int OFF_SRC    = 8;
    localparam int OFF_DST    = 12;
    localparam int DESC_BYTES = 16;
    localparam int WORD_BYTES = 4;

    // event vector positions
    localparam int EV_BC  = 0;
    localparam int EV_NR  = 1;
    localparam int NUM_EV = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_LEN,
        S_SRC,
        S_DST,
        S_RD,
        S_WR,
        S_WB,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/dcd_lane_mask.sv
module dcd_lane_mask #(
    parameter int LEN_W = 16,
    parameter int LANES = 4
) (
    input  logic [LEN_W-1:0] rem_i,
    output logic [LANES-1:0] be_o
);
    // lane i carries a byte while more than i bytes remain
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_o[i] = (rem_i > LEN_W'(i));
    end
endmodule

// File: rtl/dcd_events.sv
module dcd_events #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] evt_o,
    output logic         irq_o
);
    logic [N-1:0] evt_d, evt_q;

    always_comb begin
        evt_d = (evt_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign evt_o = evt_q;
    assign irq_o = |(evt_q & mask_i);
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [1:0]        evt_clr,
    input  logic [1:0]        evt_mask,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              evt_bc,
    output logic              evt_nr,
    output logic              irq
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        seq_state_e        st;
        logic              started;
        logic [ADDR_W-1:0] cur;
        logic [DATA_W-1:0] ctrl;
        logic [LEN_W-1:0]  rem;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [DATA_W-1:0] dword;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] ev_vec;
    logic [LANES-1:0]  tail_be;
    seq_state_e        fin_st;

    dcd_lane_mask #(.LEN_W(LEN_W), .LANES(LANES)) u_mask (
        .rem_i (r_q.rem),
        .be_o  (tail_be)
    );

    dcd_events #(.N(NUM_EV)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (evt_clr),
        .mask_i (evt_mask),
        .evt_o  (ev_vec),
        .irq_o  (irq)
    );

    always_comb begin
        r_d       = r_q;
        ev_set    = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.cur;
        mem_wdata = '0;
        mem_be    = '1;
        fin_st    = r_q.ctrl[FLG_CONT] ? S_DONE : S_WB;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.started = 1'b1;
                    if (!r_q.started) r_d.cur = tbl_base;
                    r_d.st = S_CTRL;
                end
            end
            S_CTRL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    r_d.ctrl = mem_rdata;
                    if (!mem_rdata[FLG_VALID]) begin
                        ev_set[EV_NR] = 1'b1;
                        r_d.st = S_IDLE;
                    end else begin
                        r_d.st = S_LEN;
                    end
                end
            end
            S_LEN: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + ADDR_W'(OFF_LEN);
                if (mem_ready) begin
                    r_d.rem = mem_rdata[LEN_W-1:0];
                    r_d.st  = S_SRC;
                end
            end
            S_SRC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + ADDR_W'(OFF_SRC);
                if (mem_ready) begin
                    r_d.src = mem_rdata[ADDR_W-1:0];
                    r_d.st  = S_DST;
                end
            end
            S_DST: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + ADDR_W'(OFF_DST);
                if (mem_ready) begin
                    r_d.dst = mem_rdata[ADDR_W-1:0];
                    r_d.st  = (r_q.rem == '0) ? fin_st : S_RD;
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.src;
                if (mem_ready) begin
                    r_d.dword = mem_rdata;
                    r_d.st    = S_WR;
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.dst;
                mem_wdata = r_q.dword;
                mem_be    = tail_be;
                if (mem_ready) begin
                    r_d.src = r_q.src + ADDR_W'(WORD_BYTES);
                    r_d.dst = r_q.dst + ADDR_W'(WORD_BYTES);
                    if (r_q.rem <= LEN_W'(WORD_BYTES)) begin
                        r_d.rem = '0;
                        r_d.st  = fin_st;
                    end else begin
                        r_d.rem = r_q.rem - LEN_W'(WORD_BYTES);
                        r_d.st  = S_RD;
                    end
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.ctrl & ~(DATA_W'(1) << FLG_VALID);
                if (mem_ready) r_d.st = S_DONE;
            end
            S_DONE: begin
                ev_set[EV_BC] = r_q.ctrl[FLG_INTR];
                r_d.cur = r_q.ctrl[FLG_WRAP] ? tbl_base
                                              : r_q.cur + ADDR_W'(DESC_BYTES);
                r_d.st  = (r_q.ctrl[FLG_LAST] && !r_q.ctrl[FLG_CONT]) ? S_IDLE : S_CTRL;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.st != S_IDLE);
    assign evt_bc = ev_vec[EV_BC];
    assign evt_nr = ev_vec[EV_NR];
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [3:0]        mem_be,
    input logic              evt_bc,
    input logic              evt_nr,
    input logic [1:0]        evt_clr,
    input logic [1:0]        evt_mask,
    input logic              irq
);
    assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata) && $stable(mem_be));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_nr_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_nr) |-> !busy);

    assert_sticky_bc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bc && !evt_clr[0] |=> evt_bc);

    assert_sticky_nr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_nr && !evt_clr[1] |=> evt_nr);

    assert_irq_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_bc && evt_mask[0]) || (evt_nr && evt_mask[1]) |-> irq);

    assert_irq_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_mask == 2'b00 |-> !irq);
endmodule

bind desc_chain_dma dcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .evt_bc    (evt_bc),
    .evt_nr    (evt_nr),
    .evt_clr   (evt_clr),
    .evt_mask  (evt_mask),
    .irq       (irq)
);

// File: tb/desc_chain_dma_tb.sv
module desc_chain_dma_tb;
    localparam logic [31:0] FV = 32'h8000_0000;
    localparam logic [31:0] FW = 32'h2000_0000;
    localparam logic [31:0] FI = 32'h1000_0000;
    localparam logic [31:0] FL = 32'h0800_0000;
    localparam logic [31:0] FC = 32'h0200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tbl_base = 32'h100;
    logic [1:0]  evt_clr = 2'b00;
    logic [1:0]  evt_mask = 2'b00;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic        busy, evt_bc, evt_nr, irq;

    int n_chk = 0;
    int n_bad = 0;

    // memory model and monitor state, written only by the posedge process
    logic [31:0] mem [0:255];
    logic        hw_en = 1'b0;
    logic [31:0] hw_addr = '0, hw_data = '0;
    logic        mon_clr = 1'b0;
    int          n_rd, n_wr, n_unstable;
    logic [31:0] last_rd;
    logic        bc_seen;
    logic        pend;
    logic [31:0] p_addr, p_wdata;
    logic [3:0]  p_be;
    logic        p_we;
    logic [7:0]  lfsr = 8'hA5;

    always #4 clk = ~clk;

    desc_chain_dma u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
        .evt_clr(evt_clr), .evt_mask(evt_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .evt_bc(evt_bc),
        .evt_nr(evt_nr), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= mem_req && (lfsr[1:0] != 2'b00);
    end

    always @(posedge clk) begin
        if (hw_en) mem[hw_addr[9:2]] <= hw_data;
        if (mon_clr) begin
            n_rd <= 0; n_wr <= 0; bc_seen <= 1'b0; n_unstable <= 0;
        end else if (rst_n) begin
            if (evt_bc) bc_seen <= 1'b1;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    n_wr <= n_wr + 1;
                end else begin
                    n_rd    <= n_rd + 1;
                    last_rd <= mem_addr;
                end
            end
            if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we
                         || mem_be != p_be || mem_wdata != p_wdata))
                n_unstable <= n_unstable + 1;
        end
        pend    <= rst_n && mem_req && !mem_ready;
        p_addr  <= mem_addr;
        p_we    <= mem_we;
        p_be    <= mem_be;
        p_wdata <= mem_wdata;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic desc_wr(input logic [31:0] a, input logic [31:0] c, input logic [31:0] len,
                           input logic [31:0] s, input logic [31:0] d);
        host_wr(a, c); host_wr(a + 4, len); host_wr(a + 8, s); host_wr(a + 12, d);
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        bool_loop: for (int i = 0; i < 3000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check({tag, " busy low"}, {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 evt_bc", {31'd0, evt_bc}, 32'd0);
        check("R1 evt_nr", {31'd0, evt_nr}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_chain();
        for (int i = 0; i < 3; i++) begin
            host_wr(32'h200 + 4*i, 32'hA0B1C2D3 + 32'h01010101 * i);
            host_wr(32'h300 + 4*i, 32'hFFFF_FFFF);
        end
        desc_wr(32'h100, FV | FI | 32'h0000_4000, 32'd10, 32'h200, 32'h300);
        desc_wr(32'h110, FV | FL, 32'd0, 32'h240, 32'h340);
        host_wr(32'h340, 32'h1234_5678);
        clear_mon();
        pulse_start();
        check("R13 busy after start", {31'd0, busy}, 32'd1);
        wait_idle("R9 chain");
        check("R5 word0", mem[8'hC0], 32'hA0B1C2D3);
        check("R5 word1", mem[8'hC1], 32'hA1B2C3D4);
        check("R5 tail lanes", mem[8'hC2], 32'hFFFF_C4D5);
        check("R5 zero length untouched", mem[8'hD0], 32'h1234_5678);
        check("R5 R3 reads", n_rd, 32'd11);
        check("R5 R6 writes", n_wr, 32'd5);
        check("R6 ctrl0 writeback", mem[8'h40], FI | 32'h0000_4000);
        check("R6 ctrl1 writeback", mem[8'h44], FL);
        check("R8 evt_bc", {31'd0, evt_bc}, 32'd1);
        check("R4 evt_nr clear", {31'd0, evt_nr}, 32'd0);
        check("R11 irq masked", {31'd0, irq}, 32'd0);
        @(negedge clk); evt_mask = 2'b01;
        #1 check("R11 irq enabled", {31'd0, irq}, 32'd1);
        @(negedge clk); evt_mask = 2'b10;
        #1 check("R11 irq other mask", {31'd0, irq}, 32'd0);
        @(negedge clk); evt_clr = 2'b01;
        @(negedge clk); evt_clr = 2'b00;
        check("R10 bc cleared", {31'd0, evt_bc}, 32'd0);
    endtask

    task automatic t_resume();
        host_wr(32'h120, 32'h0);
        clear_mon();
        pulse_start();
        wait_idle("R4 not ready");
        check("R4 evt_nr set", {31'd0, evt_nr}, 32'd1);
        check("R4 single read", n_rd, 32'd1);
        check("R4 no write", n_wr, 32'd0);
        check("R2 resumed at next desc", last_rd, 32'h120);
        check("R11 irq nr", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        check("R10 nr sticky", {31'd0, evt_nr}, 32'd1);
        evt_clr = 2'b10;
        @(negedge clk); evt_clr = 2'b00;
        check("R10 nr cleared", {31'd0, evt_nr}, 32'd0);
        host_wr(32'h280, 32'hCAFE_F00D);
        host_wr(32'h380, 32'h0);
        desc_wr(32'h120, FV | FW | FC | FL, 32'd4, 32'h280, 32'h380);
        clear_mon();
        pulse_start();
        wait_idle("R7 wrap");
        check("R2 R5 copy", mem[8'hE0], 32'hCAFE_F00D);
        check("R6 continuous no writeback", mem[8'h48], FV | FW | FC | FL);
        check("R6 writes", n_wr, 32'd1);
        check("R7 R9 fetch at base", last_rd, 32'h100);
        check("R9 reads", n_rd, 32'd6);
        check("R8 no bc", {31'd0, evt_bc}, 32'd0);
        check("R4 nr again", {31'd0, evt_nr}, 32'd1);
    endtask

    task automatic t_busy_overlap();
        for (int i = 0; i < 8; i++) begin
            host_wr(32'h200 + 4*i, 32'h1111_0000 + i);
            host_wr(32'h300 + 4*i, 32'h0);
        end
        desc_wr(32'h100, FV | FI | FL, 32'd32, 32'h200, 32'h300);
        clear_mon();
        @(negedge clk); evt_clr = 2'b01;
        pulse_start();
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle("R13 overlap");
        @(negedge clk);
        evt_clr = 2'b00;
        for (int i = 0; i < 8; i++)
            check("R5 block copy", mem[8'hC0 + i], 32'h1111_0000 + i);
        check("R13 reads", n_rd, 32'd12);
        check("R13 writes", n_wr, 32'd9);
        check("R10 set wins over clear", {31'd0, bc_seen}, 32'd1);
        check("R10 cleared afterwards", {31'd0, evt_bc}, 32'd0);
        check("R12 stable while waiting", n_unstable, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        t_chain();
        t_resume();
        t_busy_overlap();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule